// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers 8-bit characters from an asynchronous serial line. The line is first passed through a two-stage synchronizer and then watched at sixteen evenly spaced points per bit. A falling line starts a character. For the start bit and for each data bit, three neighbouring mid-bit points are taken and their majority decides the bit's value. A character is framed as a low start bit, eight data bits least significant first, and a high stop level.

The bit period is set by a divisor input: one bit lasts `bit_div + 1` clocks, and the receiver needs `bit_div` to be at least 16. Each recovered byte leaves on a single-cycle push strobe with its data, which can feed a receive FIFO directly. While the enable input is low, the line has no effect and nothing is pushed.

Top module: `serial_rx16`

## Requirements
- R1: After reset, `push_valid` is low and stays low while the line is held high.
- R2: One bit lasts `bit_div + 1` clocks. The sixteen oversample points of a bit are spread evenly over that period. Characters are received correctly for any divisor from 16 upward.
- R3: A bit's value is the majority of its samples at oversample points 7, 8 and 9, counted from 0. An inversion of the line that covers only one of those three points does not change the received byte.
- R4: A character starts when the synchronized line is seen low while idle. If the start bit's majority vote is high, the event is discarded as a glitch, the receiver returns to idle and nothing is pushed.
- R5: The eight data bits after the start bit are assembled least significant bit first. The first data bit on the line appears at `push_data[0]`.
- R6: Each received character raises `push_valid` for exactly one clock, with `push_data` valid in that cycle.
- R7: While `rx_enable` is low the line is ignored: no push occurs and the receiver is idle. Dropping `rx_enable` in the middle of a character aborts it without a push.
- R8: After a push, the receiver re-arms only once the line has been seen high. A line held low after the data bits yields exactly one character.
- R9: The divisor must be at least 16 whenever `rx_enable` is high. The smallest legal divisor, 16, receives correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_enable | input | 1 | Receive enable; line ignored while low |
| bit_div | input | 16 | Bit period minus one, in clocks (at least 16) |
| push_valid | output | 1 | One-cycle strobe: a character is ready |
| push_data | output | 8 | Received character, valid with `push_valid` |

## Verification
The bench sends random bytes at random divisors, stop lengths and gaps, and also covers the smallest divisor of 16. A design that spaced its oversample points by the wrong amount would drift and return corrupted bytes at the larger divisors. A two-clock inversion placed in mid-bit must be outvoted, and a start pulse shorter than half a bit must be dropped. A receiver without a majority vote would return a flipped bit; one that skipped the start check would push a spurious byte. Further cases drop the enable in the middle of a character and hold the line low past the stop position. A receiver that kept state while disabled would emit a corrupt byte, and one that re-armed without seeing a high line would push a stream of zero characters.

// File: rtl/serial_rx_pkg.sv
// Shared definitions for the oversampling serial receiver.
// Assumes: one character = start bit, DATA_BITS data bits, stop level.
package serial_rx_pkg;
    localparam int OS_RATE    = 16;  // oversample points per bit
    localparam int MAJ_FIRST  = 7;   // first oversample point used for the vote
    localparam int DATA_BITS  = 8;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/line_sync.sv
// Two-flop synchronizer for the asynchronous serial input.
// Assumes: the line idles high, so the flops reset to 1.
module line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;
    logic stable_q;

    // Capture the raw line, then re-register it to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b1;
            stable_q <= 1'b1;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/os_tick_gen.sv
// Produces OS_RATE evenly spread ticks per bit period of (div+1) clocks.
// It adds OS_RATE to a phase accumulator every clock and wraps at the period.
// Assumes: div+1 >= OS_RATE, so at most one tick falls in any clock.
module os_tick_gen #(
    parameter int DIV_W = 16,
    parameter int RATE  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int AW = DIV_W + 1;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] period;
    logic [AW-1:0] sum;

    // Bit period in clocks and the next phase value.
    always_comb begin
        period = {1'b0, div} + AW'(1);
        sum    = acc_q + AW'(RATE);
        tick   = !clear && (sum >= period);
    end

    // Advance the phase; wrap by one period on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= sum - period;
        end else begin
            acc_q <= sum;
        end
    end

    AST_PHASE_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && $stable(div) && acc_q < period) |=> (acc_q < period)); // R2
endmodule

// File: rtl/mid_bit_voter.sv
// Stores three line samples at consecutive oversample points and votes.
// Assumes: tick_idx counts 0..RATE-1 across a bit; the vote is read at bit end.
module mid_bit_voter #(
    parameter int TW    = 4,
    parameter int FIRST = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [TW-1:0] tick_idx,
    input  logic          line,
    output logic          vote
);
    logic [2:0] smp_q;

    for (genvar g = 0; g < 3; g++) begin : g_smp
        // Capture the line at oversample point FIRST+g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                smp_q[g] <= 1'b1;
            end else if (tick && tick_idx == TW'(FIRST + g)) begin
                smp_q[g] <= line;
            end
        end
    end

    // Two of three decide the bit value.
    always_comb begin
        vote = (smp_q[0] & smp_q[1]) | (smp_q[0] & smp_q[2]) | (smp_q[1] & smp_q[2]);
    end

    AST_VOTE_MAJORITY: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(smp_q) >= 2) |-> vote); // R3
endmodule

// File: rtl/serial_rx16.sv
// Serial character receiver with 16x oversampling and a 3-point mid-bit vote.
// Detects a low start bit, checks it at mid-bit, shifts in DATA_BITS bits
// least significant first and emits a one-cycle push with the byte. It then
// waits for a high line before looking for the next start.
// Assumes: bit_div >= 16 while enabled; bit_div changes only while idle.
module serial_rx16
    import serial_rx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line,
    input  logic                 rx_enable,
    input  logic [DIV_W-1:0]     bit_div,
    output logic                 push_valid,
    output logic [DATA_BITS-1:0] push_data
);
    localparam int TW = $clog2(OS_RATE);
    localparam int BW = $clog2(DATA_BITS);

    rx_state_e            state_q;
    logic [TW-1:0]        tcnt_q;
    logic [BW-1:0]        bidx_q;
    logic [DATA_BITS-1:0] shreg_q;
    logic                 push_q;
    logic                 line_s;
    logic                 tick;
    logic                 vote;
    logic                 tick_clear;
    logic                 bit_end;

    line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rx_line),
        .sync_out (line_s)
    );

    // Phase is held at zero except while a character is being timed.
    always_comb begin
        tick_clear = !rx_enable || (state_q == RX_IDLE) || (state_q == RX_STOP);
        bit_end    = tick && (tcnt_q == TW'(OS_RATE - 1));
    end

    os_tick_gen #(.DIV_W(DIV_W), .RATE(OS_RATE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tick_clear),
        .div   (bit_div),
        .tick  (tick)
    );

    mid_bit_voter #(.TW(TW), .FIRST(MAJ_FIRST)) u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .tick_idx (tcnt_q),
        .line     (line_s),
        .vote     (vote)
    );

    // Character framing state machine with the data shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            tcnt_q  <= '0;
            bidx_q  <= '0;
            shreg_q <= '0;
            push_q  <= 1'b0;
        end else begin
            push_q <= 1'b0;
            if (!rx_enable) begin
                state_q <= RX_IDLE;
            end else begin
                unique case (state_q)
                    RX_IDLE: begin
                        if (!line_s) begin
                            state_q <= RX_START;
                            tcnt_q  <= '0;
                        end
                    end
                    RX_START: begin
                        if (tick) begin
                            tcnt_q <= tcnt_q + TW'(1);
                        end
                        if (bit_end) begin
                            if (!vote) begin
                                state_q <= RX_DATA;
                                bidx_q  <= '0;
                            end else begin
                                state_q <= RX_IDLE;
                            end
                        end
                    end
                    RX_DATA: begin
                        if (tick) begin
                            tcnt_q <= tcnt_q + TW'(1);
                        end
                        if (bit_end) begin
                            shreg_q <= {vote, shreg_q[DATA_BITS-1:1]};
                            bidx_q  <= bidx_q + BW'(1);
                            if (bidx_q == BW'(DATA_BITS - 1)) begin
                                push_q  <= 1'b1;
                                state_q <= RX_STOP;
                            end
                        end
                    end
                    RX_STOP: begin
                        if (line_s) begin
                            state_q <= RX_IDLE;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign push_valid = push_q;
    assign push_data  = shreg_q;

    AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !push_valid); // R6
    AST_PUSH_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> ($past(state_q) == RX_DATA)); // R5
    AST_OFF_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !push_valid); // R7
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (state_q == RX_IDLE)); // R7
    AST_STOP_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_STOP && !line_s) |=> (state_q == RX_STOP || state_q == RX_IDLE)); // R8
    AST_DIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enable |-> (bit_div >= DIV_W'(OS_RATE))); // R9
    AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && bit_end && vote && rx_enable) |=> (state_q == RX_IDLE)); // R4
endmodule

// File: tb/serial_rx16_test.sv
module serial_rx16_test;
    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_line = 1'b1;
    logic             rx_enable = 1'b0;
    logic [DIV_W-1:0] bit_div = 16'd31;
    logic             push_valid;
    logic [7:0]       push_data;

    int         n_checks = 0;
    int         n_err = 0;
    int         n_double = 0;
    logic [7:0] got_q[$];
    logic       prev_push = 1'b0;

    always #4 clk = ~clk;

    serial_rx16 #(.DIV_W(DIV_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .rx_enable  (rx_enable),
        .bit_div    (bit_div),
        .push_valid (push_valid),
        .push_data  (push_data)
    );

    // Collect pushes away from the active edge; flag strobes longer than one clock.
    always @(negedge clk) begin
        if (rst_n && push_valid) got_q.push_back(push_data);
        if (rst_n && push_valid && prev_push) n_double++;
        prev_push = rst_n && push_valid;
    end

    function automatic logic [9:0] build_frame(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

    function automatic logic [7:0] frame_payload(input logic [9:0] f);
        return f[8:1];
    endfunction

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one frame; optional 2-clock inversion in mid of data bit glitch_bit (-1: none).
    task automatic send_byte(input logic [7:0] b, input int div, input int nstop, input int glitch_bit);
        logic [9:0] f;
        f = build_frame(b);
        for (int i = 0; i < 9; i++) begin
            rx_line = f[i];
            if (glitch_bit >= 0 && i == glitch_bit + 1) begin
                clks((div + 1) / 2);
                rx_line = ~f[i];
                clks(2);
                rx_line = f[i];
                clks(div + 1 - (div + 1) / 2 - 2);
            end else begin
                clks(div + 1);
            end
        end
        rx_line = 1'b1;
        clks(nstop * (div + 1));
    endtask

    task automatic expect_one(input logic [7:0] exp, input string req);
        check(got_q.size() == 1, req, got_q.size(), 1);
        if (got_q.size() >= 1) check(got_q[0] == exp, req, got_q[0], exp);
        got_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clks(4);
        rst_n = 1'b1;
        clks(20);
        // R1: quiet after reset
        check(push_valid == 1'b0 && got_q.size() == 0, "R1", got_q.size(), 0);

        // R9 / R5: smallest legal divisor, LSB-first assembly
        bit_div = 16'd16;
        rx_enable = 1'b1;
        clks(5);
        send_byte(8'h01, 16, 1, -1);
        expect_one(frame_payload(build_frame(8'h01)), "R5");
        send_byte(8'hA3, 16, 1, -1);
        expect_one(8'hA3, "R9");

        // R2: several fixed divisors
        rx_enable = 1'b0;
        bit_div = 16'd255;
        clks(2);
        rx_enable = 1'b1;
        clks(3);
        send_byte(8'h5A, 255, 1, -1);
        expect_one(8'h5A, "R2");

        // R2 / R5 / R6: random bytes, divisors, stop lengths and gaps
        for (int n = 0; n < 40; n++) begin
            logic [7:0] b;
            int d;
            b = 8'($urandom);
            d = 16 + int'($urandom % 40);
            rx_enable = 1'b0;
            bit_div = DIV_W'(d);
            clks(1);
            rx_enable = 1'b1;
            clks(1 + int'($urandom % 20));
            send_byte(b, d, 1 + int'($urandom % 2), -1);
            expect_one(b, "R2");
        end
        check(n_double == 0, "R6", n_double, 0);

        // R3: one-sample inversion in mid-bit is outvoted
        rx_enable = 1'b0;
        bit_div = 16'd31;
        clks(1);
        rx_enable = 1'b1;
        clks(3);
        send_byte(8'h00, 31, 1, 3);
        expect_one(8'h00, "R3");
        send_byte(8'hFF, 31, 1, 6);
        expect_one(8'hFF, "R3");

        // R4: short start pulse is discarded
        rx_line = 1'b0;
        clks(4);
        rx_line = 1'b1;
        clks(3 * 32);
        check(got_q.size() == 0, "R4", got_q.size(), 0);
        send_byte(8'hC6, 31, 1, -1);
        expect_one(8'hC6, "R4");

        // R7: disabled receiver ignores a whole frame
        rx_enable = 1'b0;
        send_byte(8'h3C, 31, 1, -1);
        check(got_q.size() == 0, "R7", got_q.size(), 0);
        // R7: abort in the middle of a character
        rx_enable = 1'b1;
        clks(2);
        rx_line = 1'b0;
        clks(4 * 32);
        rx_enable = 1'b0;
        clks(5 * 32);
        rx_line = 1'b1;
        clks(3 * 32);
        rx_enable = 1'b1;
        clks(2 * 32);
        check(got_q.size() == 0, "R7", got_q.size(), 0);
        send_byte(8'h96, 31, 1, -1);
        expect_one(8'h96, "R7");

        // R8: line held low past the stop position gives one character only
        rx_line = 1'b0;
        clks(9 * 32 + 6 * 32);
        check(got_q.size() == 1, "R8", got_q.size(), 1);
        if (got_q.size() >= 1) check(got_q[0] == 8'h00, "R8", got_q[0], 8'h00);
        got_q.delete();
        clks(4 * 32);
        check(got_q.size() == 0, "R8", got_q.size(), 0);
        rx_line = 1'b1;
        clks(32);
        send_byte(8'h81, 31, 1, -1);
        expect_one(8'h81, "R8");
        check(n_double == 0, "R6", n_double, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule